// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block performs the processor-side steps that follow once an interrupt controller has granted a request. It waits for the core to reach a point between two instructions. It then records the source code of the event in two identical event registers. It keeps copies of the current status word and program counter, and raises three control bits in the status word. Finally it points the program counter at a handler located a fixed distance above a programmable vector base.

The block has no internal state machine beyond one cycle of latency. At the clock edge where a request, an instruction boundary and a clear block bit coincide, every register update and a one-cycle redirect strobe take effect together. The fetch unit can use the new program counter at once, with no slot instruction in between. While the incoming status word has its block bit set, requests are ignored. The interrupt mask field passes through entry unchanged.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is active and until the first acceptance afterwards, every output register reads zero and the redirect strobe is low.
- R2: A request is accepted only in a cycle where both the request input and the instruction-boundary strobe are high. A request without the strobe, or the strobe without a request, causes no redirect.
- R3: When bit 28 (block) of the incoming status word is 1, a request is ignored: there is no redirect and no register changes.
- R4: On acceptance, both event registers take the value of the event code input.
- R5: On acceptance, the saved-status register takes the incoming status word and the saved-PC register takes the incoming program counter.
- R6: On acceptance, the outgoing status word equals the incoming one with bits 28 (block), 29 (bank) and 30 (mode) set to 1. Every other bit is copied, including the mask field in bits 7:4.
- R7: On acceptance, the outgoing program counter becomes the vector base plus 0x600, taken modulo 2^32.
- R8: The redirect strobe is high for exactly the one cycle after each acceptance and low otherwise. All register updates become visible in that same cycle.
- R9: In cycles without acceptance, every output register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req | input | 1 | Request granted by the interrupt controller |
| insn_boundary | input | 1 | High in cycles that fall between two instructions |
| evt_code | input | 12 | Source code of the pending event |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| vbr_in | input | 32 | Vector base |
| evt_main | output | 12 | First event register |
| evt_aux | output | 12 | Second event register |
| ssr_q | output | 32 | Saved status word |
| spc_q | output | 32 | Saved program counter |
| sr_out | output | 32 | Updated status word |
| pc_out | output | 32 | Handler address |
| redirect | output | 1 | One-cycle strobe that loads pc_out into fetch |

## Verification
The bench drives requests that arrive without a boundary strobe and boundary strobes that arrive without a request. A design that ignores the strobe would redirect in the middle of an instruction and overwrite the saved registers. It presents requests with the block bit set, where a missing block check would nest the entry and destroy the saved context. It sweeps status patterns with all-ones and all-zeros mask fields, which exposes a design that clears or sets the mask on entry. It also uses a vector base near the top of the address space, which exposes any truncation or carry error in the handler address. Back-to-back acceptances check that the redirect strobe falls when no new acceptance arrives.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned EVT_W  = 12;

  // Status word bit positions that the entry logic touches.
  localparam int unsigned SR_BLOCK = 28;
  localparam int unsigned SR_BANK  = 29;
  localparam int unsigned SR_MODE  = 30;
  localparam int unsigned SR_MASK_LO = 4;
  localparam int unsigned SR_MASK_HI = 7;

  localparam logic [WORD_W-1:0] HANDLER_OFS = 32'h0000_0600;

  function automatic logic [WORD_W-1:0] entry_set_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[SR_BLOCK] = 1'b1;
    m[SR_BANK]  = 1'b1;
    m[SR_MODE]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/exc_accept.sv
module exc_accept
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              insn_boundary,
  input  logic [WORD_W-1:0] sr_in,
  output logic              accept
);
  logic blocked;

  always_comb begin
    blocked = sr_in[SR_BLOCK];
    accept  = irq_req & insn_boundary & ~blocked;
  end

  // R2: never accept away from an instruction boundary
  assert_boundary_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> insn_boundary);
  // R3: a set block bit silences the request
  assert_block_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_in[SR_BLOCK] |-> !accept);
endmodule

// File: rtl/exc_state_save.sv
module exc_state_save
  import exc_entry_pkg::*;
#(
  parameter int unsigned NUM_EVT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [EVT_W-1:0]  evt_code,
  input  logic [WORD_W-1:0] sr_in,
  input  logic [WORD_W-1:0] pc_in,
  output logic [EVT_W-1:0]  evt_q [NUM_EVT],
  output logic [WORD_W-1:0] ssr_q,
  output logic [WORD_W-1:0] spc_q,
  output logic [WORD_W-1:0] sr_out
);
  localparam logic [WORD_W-1:0] SET_BITS = entry_set_mask();

  logic [WORD_W-1:0] ssr_d, spc_d, sr_d;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic [EVT_W-1:0] evt_d;
    always_comb begin
      evt_d = evt_q[g];
      if (accept) evt_d = evt_code;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[g] <= '0;
      else        evt_q[g] <= evt_d;
    end
  end

  always_comb begin
    ssr_d = ssr_q;
    spc_d = spc_q;
    sr_d  = sr_out;
    if (accept) begin
      ssr_d = sr_in;
      spc_d = pc_in;
      sr_d  = sr_in | SET_BITS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssr_q  <= '0;
      spc_q  <= '0;
      sr_out <= '0;
    end else begin
      ssr_q  <= ssr_d;
      spc_q  <= spc_d;
      sr_out <= sr_d;
    end
  end

  // R5: saved copies track the inputs from the accepting cycle
  assert_save_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ssr_q == $past(sr_in)) && (spc_q == $past(pc_in)));
  // R6: mask field survives entry
  assert_mask_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sr_out[SR_MASK_HI:SR_MASK_LO] == $past(sr_in[SR_MASK_HI:SR_MASK_LO]));
  // R9: nothing moves without acceptance
  assert_hold_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ssr_q) && $stable(spc_q) && $stable(sr_out));
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] vbr_in,
  output logic [WORD_W-1:0] pc_out,
  output logic              redirect
);
  logic [WORD_W-1:0] pc_d;
  logic              redirect_d;

  always_comb begin
    pc_d       = pc_out;
    redirect_d = accept;
    if (accept) pc_d = vbr_in + HANDLER_OFS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out   <= '0;
      redirect <= 1'b0;
    end else begin
      pc_out   <= pc_d;
      redirect <= redirect_d;
    end
  end

  // R7: handler address relative to the sampled vector base
  assert_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> pc_out == $past(vbr_in) + HANDLER_OFS);
  // R8: strobe only follows an acceptance
  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(accept));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              insn_boundary,
  input  logic [EVT_W-1:0]  evt_code,
  input  logic [WORD_W-1:0] sr_in,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0] vbr_in,
  output logic [EVT_W-1:0]  evt_main,
  output logic [EVT_W-1:0]  evt_aux,
  output logic [WORD_W-1:0] ssr_q,
  output logic [WORD_W-1:0] spc_q,
  output logic [WORD_W-1:0] sr_out,
  output logic [WORD_W-1:0] pc_out,
  output logic              redirect
);
  localparam int unsigned NUM_EVT = 2;

  logic             rst_sync_n;
  logic             accept;
  logic [EVT_W-1:0] evt_q [NUM_EVT];

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  exc_accept u_acc (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .irq_req       (irq_req),
    .insn_boundary (insn_boundary),
    .sr_in         (sr_in),
    .accept        (accept)
  );

  exc_state_save #(.NUM_EVT(NUM_EVT)) u_save (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .evt_code (evt_code),
    .sr_in    (sr_in),
    .pc_in    (pc_in),
    .evt_q    (evt_q),
    .ssr_q    (ssr_q),
    .spc_q    (spc_q),
    .sr_out   (sr_out)
  );

  exc_vector_gen u_vec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .vbr_in   (vbr_in),
    .pc_out   (pc_out),
    .redirect (redirect)
  );

  assign evt_main = evt_q[0];
  assign evt_aux  = evt_q[1];

  // R4: both event copies agree after an entry
  assert_evt_pair_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |-> (evt_main == evt_aux) && (evt_main == $past(evt_code)));
  // R6: control bits raised whenever the strobe fires
  assert_ctrl_bits_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |-> sr_out[30:28] == 3'b111);
  // R8: save and redirect land on the same edge
  assert_same_edge_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |-> spc_q == $past(pc_in));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req, insn_boundary;
  logic [11:0] evt_code;
  logic [31:0] sr_in, pc_in, vbr_in;
  logic [11:0] evt_main, evt_aux;
  logic [31:0] ssr_q, spc_q, sr_out, pc_out;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .evt_code(evt_code), .sr_in(sr_in), .pc_in(pc_in), .vbr_in(vbr_in),
    .evt_main(evt_main), .evt_aux(evt_aux), .ssr_q(ssr_q), .spc_q(spc_q),
    .sr_out(sr_out), .pc_out(pc_out), .redirect(redirect)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Present inputs for one cycle, then return to idle at the next falling edge.
  task automatic drive(input logic req, input logic bnd, input logic [11:0] code,
                       input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] vb);
    irq_req = req; insn_boundary = bnd; evt_code = code;
    sr_in = sr; pc_in = pc; vbr_in = vb;
    @(negedge clk);
    irq_req = 1'b0; insn_boundary = 1'b0;
    evt_code = 12'hFFF; sr_in = 32'hDEAD_BEEF; pc_in = 32'hCAFE_F00D; vbr_in = 32'h1234_5678;
  endtask

  task automatic check_entry(input string rq, input logic [11:0] code,
                             input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] vb);
    chk("R8", "redirect", {31'b0, redirect}, 32'd1);
    chk("R4", "evt_main", {20'b0, evt_main}, {20'b0, code});
    chk("R4", "evt_aux", {20'b0, evt_aux}, {20'b0, code});
    chk("R5", "ssr", ssr_q, sr);
    chk("R5", "spc", spc_q, pc);
    chk(rq, "sr_out", sr_out, sr | 32'h7000_0000);
    chk("R7", "pc_out", pc_out, vb + 32'h600);
  endtask

  task automatic t_reset();
    chk("R1", "redirect", {31'b0, redirect}, 32'd0);
    chk("R1", "ssr", ssr_q, 32'd0);
    chk("R1", "spc", spc_q, 32'd0);
    chk("R1", "sr_out", sr_out, 32'd0);
    chk("R1", "pc_out", pc_out, 32'd0);
    chk("R1", "evt", {8'b0, evt_main, evt_aux}, 32'd0);
  endtask

  task automatic t_basic();
    drive(1, 1, 12'h3A0, 32'h0000_00F0, 32'h8000_1000, 32'h8C00_0000);
    check_entry("R6", 12'h3A0, 32'h0000_00F0, 32'h8000_1000, 32'h8C00_0000);
    @(negedge clk);
    chk("R8", "redirect falls", {31'b0, redirect}, 32'd0);
    chk("R9", "pc_out held", pc_out, 32'h8C00_0600);
  endtask

  task automatic t_no_boundary();
    drive(1, 0, 12'h111, 32'h0000_0010, 32'h1111_1111, 32'h2000_0000);
    chk("R2", "no redirect without boundary", {31'b0, redirect}, 32'd0);
    chk("R9", "spc held", spc_q, 32'h8000_1000);
    chk("R9", "evt held", {20'b0, evt_main}, 32'h3A0);
    drive(0, 1, 12'h222, 32'h0000_0020, 32'h2222_2222, 32'h3000_0000);
    chk("R2", "no redirect without request", {31'b0, redirect}, 32'd0);
    chk("R9", "ssr held", ssr_q, 32'h0000_00F0);
  endtask

  task automatic t_blocked();
    drive(1, 1, 12'h555, 32'h1000_0040, 32'h5555_5555, 32'h4000_0000);
    chk("R3", "no redirect when blocked", {31'b0, redirect}, 32'd0);
    chk("R3", "sr_out held", sr_out, 32'h7000_00F0);
    chk("R3", "pc_out held", pc_out, 32'h8C00_0600);
    chk("R3", "spc held", spc_q, 32'h8000_1000);
  endtask

  task automatic t_mask_patterns();
    drive(1, 1, 12'h001, 32'h8FFF_FFFF & ~32'h1000_0000, 32'h0000_0002, 32'h0000_0000);
    check_entry("R6", 12'h001, 32'h8FFF_FFFF & ~32'h1000_0000, 32'h0000_0002, 32'h0000_0000);
    @(negedge clk);
    drive(1, 1, 12'hABC, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_1000);
    check_entry("R6", 12'hABC, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_1000);
    chk("R6", "mask zero kept", {28'b0, sr_out[7:4]}, 32'd0);
  endtask

  task automatic t_wrap();
    drive(1, 1, 12'h7FF, 32'h2000_0030, 32'h0000_4444, 32'hFFFF_FC00);
    chk("R7", "wrapped target", pc_out, 32'h0000_0200);
    chk("R6", "bank set already kept", sr_out, 32'h7000_0030);
  endtask

  task automatic t_back_to_back();
    irq_req = 1; insn_boundary = 1; evt_code = 12'h0C1;
    sr_in = 32'h4000_0080; pc_in = 32'h0000_A000; vbr_in = 32'h0001_0000;
    @(negedge clk);
    check_entry("R8", 12'h0C1, 32'h4000_0080, 32'h0000_A000, 32'h0001_0000);
    evt_code = 12'h0C2; pc_in = 32'h0000_B000; vbr_in = 32'h0002_0000;
    @(negedge clk);
    check_entry("R8", 12'h0C2, 32'h4000_0080, 32'h0000_B000, 32'h0002_0000);
    irq_req = 0; insn_boundary = 0;
    @(negedge clk);
    chk("R8", "strobe low after burst", {31'b0, redirect}, 32'd0);
    chk("R9", "spc held after burst", spc_q, 32'h0000_B000);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    irq_req = 0; insn_boundary = 0; evt_code = '0;
    sr_in = '0; pc_in = '0; vbr_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_no_boundary();
    t_blocked();
    t_mask_patterns();
    @(negedge clk);
    t_wrap();
    @(negedge clk);
    t_back_to_back();
    finish_run();
  end
endmodule